// File: doc/BRIEF.md
# Oscillator Prescaler with Startup Hold-Off Counter

This block takes the main oscillator clock and divides it with a 7-bit prescaler. Three prescaler taps (divide by 2, 4 and 64), plus an alternate low-frequency clock divided by 2, are offered to a two-bit selector that produces the system clock enable. The divide-by-128 carry of the prescaler is a timebase tick, and it also advances a 6-bit hold-off counter. The prescaler and the hold-off counter are one 13-bit chain that is loaded with 0x0078, so the delay is 8072 oscillator cycles rather than a full 8192.

The hold-off counter keeps the internal power-on reset asserted after power-up. It also blocks the system clock after a stop-mode wake-up, until the counter overflows. Overflow releases the reset and sets a sticky ready flag. After overflow the counter stays at its terminal value. A stop request freezes the whole chain. A wake event reloads the preset. Clearing the oscillator-enable bit holds the chain at the preset. Every divided output is a single-cycle enable pulse in the oscillator domain.

Top module: `startup_prescaler`

## Requirements
- R1: After the hold-off has expired, `sysClkEn` pulses once every 2 cycles for `clkSel`=00, once every 4 cycles for 01 and once every 64 cycles for 10.
- R2: With `clkSel`=11, `sysClkEn` pulses on every second `altClkEn` pulse, in the same cycle as that `altClkEn` pulse.
- R3: `tbTick` pulses once every 128 cycles while the chain runs, including during the hold-off.
- R4: While `pwrOnDet` is high the chain is loaded with 0x0078, `porRst` is 1, `ready` is 0, and `sysClkEn` and `tbTick` are 0. `sysClkEn` is never 1 while `porRst` is 1.
- R5: After `pwrOnDet` is released, `porRst` falls and `ready` rises at the 8072nd rising clock edge, and both change at the same edge.
- R6: `ready` is sticky. A one-cycle `readyClr` pulse clears it, and overflow takes priority over the clear.
- R7: After overflow the hold-off counter keeps its terminal value, so no further overflow occurs. After `ready` is cleared it stays 0, and `porRst` stays 0, until the next preset condition.
- R8: A `stopReq` pulse freezes the chain from that edge onward. `tbTick` and `sysClkEn` then stay 0 until a wake event.
- R9: A `wakeEvt` pulse while stopped reloads 0x0078 at that edge. `ready` is set at the 8072nd edge after it, `sysClkEn` stays 0 until then, and `porRst` is not asserted again.
- R10: While `oscEnable` is 0 the chain is held at 0x0078, `tbTick` and `sysClkEn` stay 0, and the hold-off restarts. `ready` is set at the 8072nd edge after `oscEnable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| pwrOnDet | input | 1 | Power-on detect; active-high synchronous preset of all state |
| oscEnable | input | 1 | Oscillator-enable control bit; 0 holds the chain at the preset |
| stopReq | input | 1 | One-cycle stop-mode entry request |
| wakeEvt | input | 1 | One-cycle wake event from stop mode |
| clkSel | input | 2 | System clock select: 00 /2, 01 /4, 10 /64, 11 alternate clock /2 |
| altClkEn | input | 1 | Alternate low-frequency clock, as a one-cycle enable pulse |
| readyClr | input | 1 | Write-one pulse that clears the ready flag |
| sysClkEn | output | 1 | Selected system clock enable pulse |
| tbTick | output | 1 | Divide-by-128 timebase tick |
| porRst | output | 1 | Internal power-on reset, active high |
| ready | output | 1 | Sticky hold-off-expired flag |

## Verification
Every output is decoded combinationally from registered state, so a tap pulse is seen in the same cycle that the prescaler holds its all-ones pattern. `ready` and `porRst` change at the 8072nd edge after the edge that loads the preset. The bench changes its inputs and samples the outputs 1 ns after each rising edge, and counts edges from the release or wake edge so that it can compare the count against exactly 8072. Tap and tick periods are taken as the number of edges between two successive pulses, and the interval right after a select change is discarded.

// File: rtl/presc_pkg.sv
package presc_pkg;
  typedef struct packed {
    logic preset;     // load the chain with its preset value
    logic advance;    // count one oscillator cycle
    logic holdDelay;  // hold-off counter keeps its terminal value
    logic clkGate;    // system clock enable may pass
  } prescStrobe_t;
endpackage

// File: rtl/presc_datapath.sv
module presc_datapath
  import presc_pkg::*;
#(
  parameter int PRE_W = 7,
  parameter int DLY_W = 6,
  parameter int PRESET = 'h78,
  parameter int NTAP = 3,
  parameter int TAP_LOG [NTAP] = '{1, 2, 6}
) (
  input  logic         clk,
  input  logic         pwrOnDet,
  input  prescStrobe_t stb,
  input  logic [1:0]   clkSel,
  input  logic         altClkEn,
  output logic         selPulse,
  output logic         tickPulse,
  output logic         ovf
);
  localparam int CHAIN_W = PRE_W + DLY_W;
  localparam logic [CHAIN_W-1:0] PRESET_V = CHAIN_W'(PRESET);
  localparam logic [PRE_W-1:0] PRE_ONES = '1;
  localparam logic [DLY_W-1:0] DLY_ONES = '1;

  logic [PRE_W-1:0] preQ;
  logic [DLY_W-1:0] dlyQ;
  logic             altTogQ;
  logic [NTAP-1:0]  tapPulse;
  logic             altPulse;
  logic             preCarry;

  assign preCarry = (preQ == PRE_ONES);

  always_ff @(posedge clk) begin
    if (pwrOnDet || stb.preset) begin
      preQ <= PRESET_V[PRE_W-1:0];
      dlyQ <= PRESET_V[CHAIN_W-1:PRE_W];
    end else if (stb.advance) begin
      preQ <= preQ + 1'b1;
      if (preCarry && !stb.holdDelay && (dlyQ != DLY_ONES))
        dlyQ <= dlyQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pwrOnDet) altTogQ <= 1'b0;
    else if (stb.advance && altClkEn) altTogQ <= ~altTogQ;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << TAP_LOG[g]) - 1);
    assign tapPulse[g] = stb.advance && ((preQ & MASK) == MASK);
  end

  assign altPulse  = stb.advance && altClkEn && altTogQ;
  assign tickPulse = stb.advance && preCarry;
  assign ovf       = stb.advance && preCarry && (dlyQ == DLY_ONES) && !stb.holdDelay;

  always_comb begin
    unique case (clkSel)
      2'b00:   selPulse = tapPulse[0];
      2'b01:   selPulse = tapPulse[1];
      2'b10:   selPulse = tapPulse[2];
      default: selPulse = altPulse;
    endcase
  end

  // R10: the preset strobe leaves the chain at the preset value.
  assert_preset_load_R10: assert property (@(posedge clk) disable iff (pwrOnDet)
    stb.preset |=> ({dlyQ, preQ} == PRESET_V));
  // R8: with neither advance nor preset, the chain keeps its value.
  assert_freeze_R8: assert property (@(posedge clk) disable iff (pwrOnDet)
    (!stb.advance && !stb.preset) |=> $stable({dlyQ, preQ}));
  // R7: after overflow the hold-off field does not move.
  assert_delay_hold_R7: assert property (@(posedge clk) disable iff (pwrOnDet)
    (stb.holdDelay && !stb.preset) |=> $stable(dlyQ));
endmodule

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
(
  input  logic         clk,
  input  logic         pwrOnDet,
  input  logic         oscEnable,
  input  logic         stopReq,
  input  logic         wakeEvt,
  input  logic         readyClr,
  input  logic         ovf,
  output prescStrobe_t stb,
  output logic         porRst,
  output logic         ready,
  output logic         stopped
);
  logic stoppedQ, doneQ, readyQ, porQ;

  always_comb begin
    stb.preset    = !oscEnable || (stoppedQ && wakeEvt);
    stb.advance   = !pwrOnDet && oscEnable && !stoppedQ && !stopReq;
    stb.holdDelay = doneQ;
    stb.clkGate   = doneQ && !stoppedQ;
  end

  always_ff @(posedge clk) begin
    if (pwrOnDet) begin
      stoppedQ <= 1'b0;
      doneQ    <= 1'b0;
      readyQ   <= 1'b0;
      porQ     <= 1'b1;
    end else begin
      if (!oscEnable) begin
        stoppedQ <= 1'b0;
        doneQ    <= 1'b0;
      end else if (stoppedQ) begin
        if (wakeEvt) begin
          stoppedQ <= 1'b0;
          doneQ    <= 1'b0;
        end
      end else if (stopReq) begin
        stoppedQ <= 1'b1;
      end else if (ovf) begin
        doneQ <= 1'b1;
      end
      if (ovf) porQ <= 1'b0;
      if (ovf) readyQ <= 1'b1;
      else if (readyClr) readyQ <= 1'b0;
    end
  end

  assign porRst  = porQ;
  assign ready   = readyQ;
  assign stopped = stoppedQ;

  // R5: the reset is released at the same edge that sets the ready flag.
  assert_por_ready_R5: assert property (@(posedge clk) disable iff (pwrOnDet)
    $fell(porQ) |-> readyQ);
  // R6: the ready flag holds until a clear pulse.
  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (pwrOnDet)
    (readyQ && !readyClr) |=> readyQ);
  // R9: once released, the reset is not asserted again by stop or wake.
  assert_por_stays_low_R9: assert property (@(posedge clk) disable iff (pwrOnDet)
    !porQ |=> !porQ);
endmodule

// File: rtl/startup_prescaler.sv
module startup_prescaler
  import presc_pkg::*;
#(
  parameter int PRE_W = 7,
  parameter int DLY_W = 6,
  parameter int PRESET = 'h78
) (
  input  logic       clk,
  input  logic       pwrOnDet,
  input  logic       oscEnable,
  input  logic       stopReq,
  input  logic       wakeEvt,
  input  logic [1:0] clkSel,
  input  logic       altClkEn,
  input  logic       readyClr,
  output logic       sysClkEn,
  output logic       tbTick,
  output logic       porRst,
  output logic       ready
);
  prescStrobe_t stb;
  logic ovf, selPulse, stopped;

  presc_ctrl u_ctrl (
    .clk(clk), .pwrOnDet(pwrOnDet), .oscEnable(oscEnable), .stopReq(stopReq),
    .wakeEvt(wakeEvt), .readyClr(readyClr), .ovf(ovf), .stb(stb),
    .porRst(porRst), .ready(ready), .stopped(stopped)
  );

  presc_datapath #(.PRE_W(PRE_W), .DLY_W(DLY_W), .PRESET(PRESET)) u_dp (
    .clk(clk), .pwrOnDet(pwrOnDet), .stb(stb), .clkSel(clkSel),
    .altClkEn(altClkEn), .selPulse(selPulse), .tickPulse(tbTick), .ovf(ovf)
  );

  assign sysClkEn = selPulse && stb.clkGate;

  // R4: no system clock while the power-on reset is held.
  assert_no_clk_in_reset_R4: assert property (@(posedge clk) disable iff (pwrOnDet)
    porRst |-> !sysClkEn);
  // R8: stopped means quiet outputs.
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (pwrOnDet)
    stopped |-> (!tbTick && !sysClkEn));
  // R10: a disabled oscillator gives no tick.
  assert_osc_off_quiet_R10: assert property (@(posedge clk) disable iff (pwrOnDet)
    !oscEnable |-> (!tbTick && !sysClkEn));
endmodule

// File: tb/sim_startup_prescaler.sv
`timescale 1ns/1ps
module sim_startup_prescaler;
  localparam int DELAY = 8072;
  localparam int NVEC = 5;
  // {clkSel, altPeriod, expected interval}
  localparam int VEC [NVEC][3] = '{'{0, 0, 2}, '{1, 0, 4}, '{2, 0, 64},
                                   '{3, 3, 6}, '{3, 5, 10}};

  logic clk = 1'b0;
  logic pwrOnDet = 1'b1, oscEnable = 1'b1, stopReq = 1'b0, wakeEvt = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic altClkEn = 1'b0, readyClr = 1'b0;
  logic sysClkEn, tbTick, porRst, ready;
  int altPer = 0;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  startup_prescaler u0 (
    .clk(clk), .pwrOnDet(pwrOnDet), .oscEnable(oscEnable), .stopReq(stopReq),
    .wakeEvt(wakeEvt), .clkSel(clkSel), .altClkEn(altClkEn), .readyClr(readyClr),
    .sysClkEn(sysClkEn), .tbTick(tbTick), .porRst(porRst), .ready(ready)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edges between two successive sysClkEn pulses (second interval after call).
  task automatic measureSys(output int iv);
    int n;
    iv = -1;
    for (int k = 0; k < 2; k++) begin
      n = 0;
      while (!sysClkEn && n < 1000) begin tick(); n++; end
      tick(); n = 1;
      while (!sysClkEn && n < 1000) begin tick(); n++; end
      iv = n;
    end
  endtask

  // Count edges until ready rises; flag sysClkEn or porRst seen on the way.
  task automatic countHold(output int n, output int sawClk, output int sawPor);
    n = 0; sawClk = 0; sawPor = 0;
    while (n < DELAY + 200) begin
      tick(); n++;
      if (ready) break;
      if (sysClkEn) sawClk++;
      if (porRst) sawPor++;
    end
  endtask

  task automatic pulseClr();
    readyClr = 1'b1; tick(); readyClr = 1'b0;
  endtask

  initial begin : altGen
    forever begin
      if (altPer > 0) begin
        repeat (altPer - 1) tick();
        altClkEn = 1'b1; tick(); altClkEn = 1'b0;
      end else tick();
    end
  end

  initial begin : watchdog
    #1000000;
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : mainSeq
    int n, sawClk, sawPor, firstTick, secondTick, ticks, iv;
    repeat (5) tick();
    // R4: reset state
    check(porRst == 1'b1, "R4 porRst in reset", porRst, 1);
    check(ready == 1'b0, "R4 ready in reset", ready, 0);
    check(sysClkEn == 1'b0 && tbTick == 1'b0, "R4 quiet in reset", sysClkEn | tbTick, 0);

    // R5 / R3: power-on hold-off
    pwrOnDet = 1'b0;
    n = 0; sawClk = 0; firstTick = -1; secondTick = -1;
    while (porRst && n < DELAY + 200) begin
      tick(); n++;
      if (sysClkEn && porRst) sawClk++;
      if (tbTick) begin
        if (firstTick < 0) firstTick = n;
        else if (secondTick < 0) secondTick = n;
      end
    end
    check(n == DELAY, "R5 power-on delay edges", n, DELAY);
    check(ready == 1'b1, "R5 ready at release", ready, 1);
    check(sawClk == 0, "R4 no sysClkEn during porRst", sawClk, 0);
    check(secondTick - firstTick == 128, "R3 timebase period", secondTick - firstTick, 128);

    // R1 / R2: select vector table
    for (int v = 0; v < NVEC; v++) begin
      clkSel = 2'(VEC[v][0]);
      altPer = VEC[v][1];
      measureSys(iv);
      check(iv == VEC[v][2], (VEC[v][0] == 3) ? "R2 alt clock interval" : "R1 tap interval",
            iv, VEC[v][2]);
    end
    altPer = 0;
    clkSel = 2'b00;

    // R6: sticky ready, write-one clear
    repeat (20) tick();
    check(ready == 1'b1, "R6 ready sticky", ready, 1);
    pulseClr();
    check(ready == 1'b0, "R6 ready cleared", ready, 0);

    // R7: no second overflow
    n = 0;
    for (int k = 0; k < DELAY + 1000; k++) begin tick(); if (ready || porRst) n++; end
    check(n == 0, "R7 no further overflow", n, 0);

    // R8: stop freezes
    stopReq = 1'b1; tick(); stopReq = 1'b0;
    n = 0;
    for (int k = 0; k < 300; k++) begin tick(); if (tbTick || sysClkEn) n++; end
    check(n == 0, "R8 quiet while stopped", n, 0);

    // R9: wake reloads the preset
    wakeEvt = 1'b1; tick(); wakeEvt = 1'b0;
    countHold(n, sawClk, sawPor);
    check(n == DELAY, "R9 wake delay edges", n, DELAY);
    check(sawClk == 0, "R9 no sysClkEn before ready", sawClk, 0);
    check(sawPor == 0 && porRst == 1'b0, "R9 porRst stays low", sawPor + porRst, 0);
    measureSys(iv);
    check(iv == 2, "R9 clock resumes", iv, 2);

    // R10: oscillator disabled holds the preset
    pulseClr();
    oscEnable = 1'b0;
    ticks = 0;
    for (int k = 0; k < 300; k++) begin tick(); if (tbTick || sysClkEn) ticks++; end
    check(ticks == 0, "R10 quiet while disabled", ticks, 0);
    oscEnable = 1'b1;
    n = 0; sawClk = 0;
    while (!ready && n < DELAY + 200) begin
      tick(); n++;
      if (sysClkEn && !ready) sawClk++;
    end
    check(n == DELAY, "R10 re-enable delay edges", n, DELAY);
    check(sawClk == 0, "R10 no sysClkEn before ready", sawClk, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule